// File: doc/BRIEF.md
# DMA Source-Chain Tag Sequencer

This block works out the address registers of a source-chain DMA channel each time a tag has been decoded. A fetch unit outside the block reads a tag and presents three things for one cycle: the tag kind, the address carried in the tag and the transfer length in quadwords. On the next clock edge the sequencer updates its registers. These are the tag pointer (where the next tag sits), the data pointer (where the payload starts), a small return-address stack with its depth count, and an end-of-chain flag. A data mover outside the block uses the data pointer. The fetch unit uses the tag pointer to fetch the next tag.

A start strobe loads a fresh tag pointer and empties the stack. A mode pin selects between two behaviours. In stacked mode, subroutine-style call and return tags are honoured. In stackless mode those two tags close the chain. When a counted-inline transfer finishes, the data mover reports its final data address. The tag pointer then moves to that address, so the following tag is read from just past the inline data. The interface is made of plain strobes with no back-pressure. A tag strobe is taken in any cycle where no start is present and the chain has not ended. In every other cycle it is dropped.

Top module: `chain_tag_seq`

## Requirements
- R1: After reset, tag pointer, data pointer, every stack entry and the stack depth read 0, and the chain-end, done and call-error outputs are low.
- R2: A start strobe loads the tag pointer from the start value, sets the data pointer to 0, empties the stack (entries 0, depth 0) and clears the chain-end flag. A start in the same cycle as a tag wins over the tag.
- R3: Reference tags, codes 0 (reference-and-end), 3 (reference) and 4 (reference with stall), set the data pointer to the tag address and add 16 to the tag pointer. Code 0 also ends the chain; codes 3 and 4 do not.
- R4: Counted-inline tag, code 1: the data pointer and the tag pointer both become old tag pointer + 16, and the chain continues.
- R5: Next tag, code 2: the data pointer becomes old tag pointer + 16 and the tag pointer takes the tag address.
- R6: End tag, code 7: the data pointer becomes old tag pointer + 16, the tag pointer is left unchanged, and the chain ends.
- R7: Call tag, code 5, stacked mode, non-zero address, depth below 2: the data pointer becomes T+16 (T = old tag pointer). The value T+16+16*qwc is written to entry 0 when the depth is 0, or to entry 1 when the depth is 1. The depth then increments and the tag pointer takes the tag address.
- R8: Call tag in stacked mode, non-zero address, depth already 2: the chain ends, the data pointer becomes T+16, and the tag pointer and the stack are unchanged.
- R9: Call tag in stacked mode with tag address 0: call-error pulses high for one cycle, nothing is pushed, the data pointer becomes T+16, the tag pointer becomes T+16+16*qwc, and the chain continues. This case is checked before the overflow case.
- R10: Return tag, code 6, stacked mode: the data pointer becomes T+16. At depth 2 the tag pointer loads entry 1; at depth 1 it loads entry 0. The used entry is cleared to 0 and the depth decrements. At depth 0 the chain ends and the tag pointer is unchanged.
- R11: In stackless mode (mode pin low), call and return tags act as an end tag: the data pointer becomes T+16, the tag pointer and the stack are unchanged, the chain ends, and no call error is raised.
- R12: Each tag that ends the chain raises done for exactly one cycle, and chain-end stays high alongside it. While chain-end is high, tag strobes are ignored: no register changes and no done pulse occurs.
- R13: A transfer-done strobe right after an accepted code-1 tag sets the tag pointer to the reported final data address. After any other tag kind, the strobe leaves the tag pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a new chain |
| start_tadr_i | input | AW | First tag address for the new chain |
| stack_en_i | input | 1 | 1 = call/return honoured, 0 = stackless |
| tag_valid_i | input | 1 | Decoded tag present this cycle |
| tag_id_i | input | 3 | Tag kind code |
| tag_addr_i | input | AW | Address field of the tag |
| tag_qwc_i | input | QW | Transfer length in quadwords |
| xfer_done_i | input | 1 | Inline data transfer finished |
| xfer_madr_i | input | AW | Data address reached at the end of the transfer |
| tadr_o | output | AW | Tag pointer |
| madr_o | output | AW | Data pointer |
| stack_o | output | DEPTH*AW | Return stack, entry i at bits i*AW upward |
| sp_o | output | SPW | Stack depth |
| chain_end_o | output | 1 | Chain has ended |
| done_o | output | 1 | One-cycle pulse when the chain ends |
| call_err_o | output | 1 | One-cycle pulse for a call with address 0 |

## Verification
The assertions assume that xfer_done_i never arrives in the same cycle as an accepted tag, and that a start is the only way out of an ended chain. The stimulus keeps to both by using separate tasks: each one drives exactly one strobe per cycle at the falling edge. The checks sweep every tag code in both modes, at every reachable stack depth, with zero and non-zero tag addresses. Each case begins with a start strobe, so the stack depth is never pushed past its bound by anything other than the overflow case under test.

// File: rtl/chain_tag_pkg.sv
package chain_tag_pkg;
  typedef enum logic [2:0] {
    TG_REF_END  = 3'd0,
    TG_INLINE   = 3'd1,
    TG_JUMP     = 3'd2,
    TG_REF      = 3'd3,
    TG_REF_STL  = 3'd4,
    TG_CALL     = 3'd5,
    TG_RETURN   = 3'd6,
    TG_STOP     = 3'd7
  } tag_kind_e;
endpackage

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int AW    = 32,
  parameter int DEPTH = 2,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [AW-1:0]     push_val_i,
  output logic [AW-1:0]     top_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [SPW-1:0]    sp_o,
  output logic [DEPTH*AW-1:0] ent_o
);
  logic [SPW-1:0] sp_q;
  logic [AW-1:0]  ent_q [DEPTH];

  assign full_o  = (sp_q == SPW'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign sp_o    = sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sp_q <= '0;
    else if (clr_i)            sp_q <= '0;
    else if (push_i && !full_o) sp_q <= sp_q + 1'b1;
    else if (pop_i && !empty_o) sp_q <= sp_q - 1'b1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  ent_q[i] <= '0;
      else if (clr_i)                              ent_q[i] <= '0;
      else if (push_i && sp_q == SPW'(i))          ent_q[i] <= push_val_i;
      else if (pop_i && sp_q == SPW'(i + 1))       ent_q[i] <= '0;
    end
    assign ent_o[i*AW +: AW] = ent_q[i];
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sp_q == SPW'(i + 1)) top_o = ent_q[i];
  end

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o); // R7
  AST_POP_HAS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o); // R10
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp_q <= SPW'(DEPTH)); // R8
endmodule

// File: rtl/tag_step_calc.sv
module tag_step_calc
  import chain_tag_pkg::*;
#(
  parameter int AW     = 32,
  parameter int QW     = 16,
  parameter int QBYTES = 16,
  localparam int QSH   = $clog2(QBYTES)
) (
  input  logic [2:0]    tag_id_i,
  input  logic [AW-1:0] tag_addr_i,
  input  logic [QW-1:0] tag_qwc_i,
  input  logic [AW-1:0] tadr_i,
  input  logic          stack_en_i,
  input  logic          full_i,
  input  logic          empty_i,
  input  logic [AW-1:0] top_i,
  output logic [AW-1:0] tadr_o,
  output logic [AW-1:0] madr_o,
  output logic [AW-1:0] push_val_o,
  output logic          push_o,
  output logic          pop_o,
  output logic          end_o,
  output logic          err_o
);
  logic [AW-1:0] after_tag;
  logic [AW-1:0] span;

  assign after_tag  = tadr_i + AW'(QBYTES);
  assign span       = AW'(tag_qwc_i) << QSH;
  assign push_val_o = after_tag + span;

  always_comb begin
    tadr_o = tadr_i;
    madr_o = after_tag;
    push_o = 1'b0;
    pop_o  = 1'b0;
    end_o  = 1'b0;
    err_o  = 1'b0;
    unique case (tag_kind_e'(tag_id_i))
      TG_REF_END: begin
        madr_o = tag_addr_i;
        tadr_o = after_tag;
        end_o  = 1'b1;
      end
      TG_REF, TG_REF_STL: begin
        madr_o = tag_addr_i;
        tadr_o = after_tag;
      end
      TG_INLINE: tadr_o = after_tag;
      TG_JUMP:   tadr_o = tag_addr_i;
      TG_CALL: begin
        if (!stack_en_i) end_o = 1'b1;
        else if (tag_addr_i == '0) begin
          err_o  = 1'b1;
          tadr_o = push_val_o;
        end else if (full_i) end_o = 1'b1;
        else begin
          push_o = 1'b1;
          tadr_o = tag_addr_i;
        end
      end
      TG_RETURN: begin
        if (!stack_en_i || empty_i) end_o = 1'b1;
        else begin
          pop_o  = 1'b1;
          tadr_o = top_i;
        end
      end
      TG_STOP: end_o = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/chain_tag_seq.sv
module chain_tag_seq
  import chain_tag_pkg::*;
#(
  parameter int AW     = 32,
  parameter int QW     = 16,
  parameter int DEPTH  = 2,
  parameter int QBYTES = 16,
  localparam int SPW   = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [AW-1:0]       start_tadr_i,
  input  logic                stack_en_i,
  input  logic                tag_valid_i,
  input  logic [2:0]          tag_id_i,
  input  logic [AW-1:0]       tag_addr_i,
  input  logic [QW-1:0]       tag_qwc_i,
  input  logic                xfer_done_i,
  input  logic [AW-1:0]       xfer_madr_i,
  output logic [AW-1:0]       tadr_o,
  output logic [AW-1:0]       madr_o,
  output logic [DEPTH*AW-1:0] stack_o,
  output logic [SPW-1:0]      sp_o,
  output logic                chain_end_o,
  output logic                done_o,
  output logic                call_err_o
);
  logic [AW-1:0] tadr_q, madr_q;
  logic          ended_q, inline_q, done_q, err_q;
  logic          accept;
  logic [AW-1:0] c_tadr, c_madr, c_pval, stk_top;
  logic          c_push, c_pop, c_end, c_err, stk_full, stk_empty;

  assign accept = tag_valid_i && !start_i && !ended_q;

  tag_step_calc #(.AW(AW), .QW(QW), .QBYTES(QBYTES)) calc_i (
    .tag_id_i(tag_id_i), .tag_addr_i(tag_addr_i), .tag_qwc_i(tag_qwc_i),
    .tadr_i(tadr_q), .stack_en_i(stack_en_i), .full_i(stk_full),
    .empty_i(stk_empty), .top_i(stk_top), .tadr_o(c_tadr), .madr_o(c_madr),
    .push_val_o(c_pval), .push_o(c_push), .pop_o(c_pop), .end_o(c_end),
    .err_o(c_err)
  );

  ret_addr_stack #(.AW(AW), .DEPTH(DEPTH)) stack_i (
    .clk(clk), .rst_n(rst_n), .clr_i(start_i),
    .push_i(accept && c_push), .pop_i(accept && c_pop),
    .push_val_i(c_pval), .top_o(stk_top), .full_o(stk_full),
    .empty_o(stk_empty), .sp_o(sp_o), .ent_o(stack_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tadr_q   <= '0;
      madr_q   <= '0;
      ended_q  <= 1'b0;
      inline_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (start_i) begin
        tadr_q   <= start_tadr_i;
        madr_q   <= '0;
        ended_q  <= 1'b0;
        inline_q <= 1'b0;
      end else if (accept) begin
        tadr_q   <= c_tadr;
        madr_q   <= c_madr;
        ended_q  <= c_end;
        done_q   <= c_end;
        err_q    <= c_err;
        inline_q <= (tag_id_i == TG_INLINE);
      end else if (xfer_done_i && inline_q) begin
        tadr_q   <= xfer_madr_i;
        inline_q <= 1'b0;
      end
    end
  end

  assign tadr_o      = tadr_q;
  assign madr_o      = madr_q;
  assign chain_end_o = ended_q;
  assign done_o      = done_q;
  assign call_err_o  = err_q;

  AST_DONE_WITH_END: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> chain_end_o); // R12
  AST_IGNORE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_end_o && tag_valid_i && !start_i && !xfer_done_i) |=> $stable(tadr_o)); // R12
  AST_STOP_KEEPS_TADR: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tag_id_i == TG_STOP) |=> (tadr_o == $past(tadr_o))); // R6
  AST_ERR_FROM_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && tag_id_i != TG_CALL) |=> !call_err_o); // R9
  AST_START_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (sp_o == '0 && !chain_end_o)); // R2
endmodule

// File: tb/chain_tag_seq_tb_top.sv
module chain_tag_seq_tb_top;
  localparam int AW = 32;
  localparam int QW = 16;
  localparam int DEPTH = 2;
  localparam int SPW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_i = 0, stack_en_i = 0, tag_valid_i = 0, xfer_done_i = 0;
  logic [AW-1:0] start_tadr_i = '0, tag_addr_i = '0, xfer_madr_i = '0;
  logic [2:0] tag_id_i = '0;
  logic [QW-1:0] tag_qwc_i = '0;
  logic [AW-1:0] tadr_o, madr_o;
  logic [DEPTH*AW-1:0] stack_o;
  logic [SPW-1:0] sp_o;
  logic chain_end_o, done_o, call_err_o;

  int checks = 0, fails = 0;
  logic [AW-1:0] m_tadr, m_madr, m_s0, m_s1;
  int m_sp;
  logic m_end, m_done, m_err, m_inline;

  always #5 clk = ~clk;

  chain_tag_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_tadr_i(start_tadr_i),
    .stack_en_i(stack_en_i), .tag_valid_i(tag_valid_i), .tag_id_i(tag_id_i),
    .tag_addr_i(tag_addr_i), .tag_qwc_i(tag_qwc_i), .xfer_done_i(xfer_done_i),
    .xfer_madr_i(xfer_madr_i), .tadr_o(tadr_o), .madr_o(madr_o),
    .stack_o(stack_o), .sp_o(sp_o), .chain_end_o(chain_end_o),
    .done_o(done_o), .call_err_o(call_err_o)
  );

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_all(input string req);
    chk({req, " tadr"}, tadr_o, m_tadr);
    chk({req, " madr"}, madr_o, m_madr);
    chk({req, " stack0"}, stack_o[AW-1:0], m_s0);
    chk({req, " stack1"}, stack_o[2*AW-1:AW], m_s1);
    chk({req, " depth"}, AW'(sp_o), AW'(m_sp));
    chk({req, " end"}, AW'(chain_end_o), AW'(m_end));
    chk({req, " done"}, AW'(done_o), AW'(m_done));
    chk({req, " err"}, AW'(call_err_o), AW'(m_err));
  endtask

  task automatic do_start(input logic [AW-1:0] t);
    @(negedge clk);
    start_i = 1; start_tadr_i = t;
    @(negedge clk);
    start_i = 0;
    m_tadr = t; m_madr = '0; m_s0 = '0; m_s1 = '0; m_sp = 0;
    m_end = 0; m_done = 0; m_err = 0; m_inline = 0;
  endtask

  // Model of R3..R12, independent of the RTL structure
  task automatic do_tag(input logic [2:0] id, input logic [AW-1:0] a, input logic [QW-1:0] q);
    logic [AW-1:0] t16, ret;
    @(negedge clk);
    tag_valid_i = 1; tag_id_i = id; tag_addr_i = a; tag_qwc_i = q;
    @(negedge clk);
    tag_valid_i = 0;
    m_done = 0; m_err = 0;
    if (m_end) return;
    t16 = m_tadr + 32'd16;
    ret = t16 + (AW'(q) * 32'd16);
    m_inline = (id == 3'd1);
    case (id)
      3'd0: begin m_madr = a; m_tadr = t16; m_end = 1; end
      3'd3, 3'd4: begin m_madr = a; m_tadr = t16; end
      3'd1: begin m_madr = t16; m_tadr = t16; end
      3'd2: begin m_madr = t16; m_tadr = a; end
      3'd7: begin m_madr = t16; m_end = 1; end
      3'd5: begin
        m_madr = t16;
        if (!stack_en_i) m_end = 1;
        else if (a == 0) begin m_err = 1; m_tadr = ret; end
        else if (m_sp == 2) m_end = 1;
        else begin
          if (m_sp == 0) m_s0 = ret; else m_s1 = ret;
          m_sp++; m_tadr = a;
        end
      end
      default: begin
        m_madr = t16;
        if (!stack_en_i || m_sp == 0) m_end = 1;
        else if (m_sp == 2) begin m_tadr = m_s1; m_s1 = '0; m_sp = 1; end
        else begin m_tadr = m_s0; m_s0 = '0; m_sp = 0; end
      end
    endcase
    m_done = m_end;
  endtask

  task automatic do_xfer(input logic [AW-1:0] fm);
    @(negedge clk);
    xfer_done_i = 1; xfer_madr_i = fm;
    @(negedge clk);
    xfer_done_i = 0;
    m_done = 0; m_err = 0;
    if (m_inline) begin m_tadr = fm; m_inline = 0; end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    m_tadr = '0; m_madr = '0; m_s0 = '0; m_s1 = '0; m_sp = 0;
    m_end = 0; m_done = 0; m_err = 0; m_inline = 0;
    repeat (3) @(negedge clk);
    compare_all("R1 reset");
    rst_n = 1;
    @(negedge clk);

    // R2: start wins over a simultaneous tag
    @(negedge clk);
    start_i = 1; start_tadr_i = 32'h0000_4000; tag_valid_i = 1; tag_id_i = 3'd2;
    tag_addr_i = 32'h0000_9990;
    @(negedge clk);
    start_i = 0; tag_valid_i = 0;
    m_tadr = 32'h0000_4000;
    compare_all("R2 start priority");

    for (int mode = 0; mode < 2; mode++) begin
      for (int pre = 0; pre < 3; pre++) begin
        if (mode == 0 && pre > 0) continue;
        for (int id = 0; id < 8; id++) begin
          for (int az = 0; az < 2; az++) begin
            stack_en_i = mode[0];
            do_start(32'h0001_0000 + AW'(id * 32'h100));
            compare_all("R2 start");
            for (int p = 0; p < pre; p++) begin
              do_tag(3'd5, 32'h0002_0000 + AW'(p * 32'h40), QW'(p + 3));
              compare_all("R7 pre call");
            end
            do_tag(id[2:0], (az == 1) ? '0 : 32'h0003_0500 + AW'(id * 16), QW'(id + 1));
            case (id)
              0, 3, 4: compare_all("R3 reference");
              1: compare_all("R4 inline");
              2: compare_all("R5 next");
              7: compare_all("R6 end");
              5: compare_all(mode == 0 ? "R11 stackless call" :
                             (az == 1 ? "R9 call zero" : (pre == 2 ? "R8 overflow" : "R7 call")));
              default: compare_all(mode == 0 ? "R11 stackless ret" : "R10 return");
            endcase
            // R12: follow-up tag must be ignored if ended, done drops
            do_tag(3'd2, 32'h0007_7700, QW'(2));
            compare_all("R12 follow-up");
            if (id == 1) begin
              // R4 inline still pending only if the follow-up was not accepted
              do_start(32'h0005_0000);
              do_tag(3'd1, 32'h0, QW'(4));
              do_xfer(32'h0005_0050);
              compare_all("R13 inline advance");
            end
            if (id == 3) begin
              do_xfer(32'h0006_6660);
              compare_all("R13 no advance after reference");
            end
          end
        end
      end
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule